// File: doc/BRIEF.md
# Pointer Register Address Generator

This block forms the effective data-memory address for a load or store. It receives a three-bit addressing-mode code, a 16-bit absolute address, a six-bit unsigned offset and a choice of one of three 16-bit pointers. The pointers live in the six highest byte registers of a 32-entry register file, indices 26 to 31, and the block sees them on a flat input bus. It returns the effective address. In the two auto-modify modes it also returns the new pointer value and the register index it must be written to.

A request is presented with `req_valid`. With the default registered variant, every result appears together one clock later, qualified by `out_valid`. The pointer write-back (`wb_en`, `wb_idx`, `wb_value`) is valid in the same cycle as the address. The register file can therefore commit the two pointer bytes as one atomic update. Combinations that are not allowed raise `illegal` and never produce a write-back. Instruction decoding and the memory access itself happen elsewhere.

Top module: `ptr_agen`

## Requirements
- R1: Mode code 0 (absolute) gives `ea` = `direct_addr`, any 16-bit value, with no write-back and no `illegal`, whatever `ptr_sel` holds.
- R2: `rf_ptr_bytes[8k+7:8k]` holds register 26+k. The pointer is the high register in bits 15:8 and the low register in bits 7:0. `ptr_sel` 0 selects the 27:26 pair, 1 selects 29:28 and 2 selects 31:30. `wb_idx` is the low-byte index of the selected pair: 26, 28 or 30.
- R3: Mode code 1 (plain indirect) gives `ea` = the selected pointer, with no write-back.
- R4: Mode code 2 (offset) with `ptr_sel` 1 or 2 gives `ea` = pointer + zero-extended `disp` (0..63), modulo 2^16, with no write-back.
- R5: Mode code 2 with `ptr_sel` 0 raises `illegal` and gives `ea` = 0, with no write-back.
- R6: Mode code 3 (decrement-first) gives `ea` = pointer − 1 modulo 2^16, and writes that same value back to the pointer.
- R7: Mode code 4 (increment-after) gives `ea` = the unmodified pointer, and writes pointer + 1 modulo 2^16 back.
- R8: Mode codes 5 to 7, or `ptr_sel` 3 in any pointer-based mode, raise `illegal` and give `ea` = 0, with no write-back.
- R9: Results appear one clock after a `req_valid` cycle. `out_valid` is high exactly then. `wb_en` and `illegal` are never high without `out_valid`, and never high together.
- R10: While `rst_n` is low, `out_valid`, `wb_en`, `illegal` and `ea` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| mode | input | 3 | Addressing-mode code (0..4 legal) |
| ptr_sel | input | 2 | Pointer choice: 0, 1, 2; 3 is invalid |
| direct_addr | input | 16 | Absolute address for mode 0 |
| disp | input | 6 | Unsigned offset for mode 2 |
| rf_ptr_bytes | input | 48 | Register file bytes 26..31, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Result strobe / update enable |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Pointer write-back request |
| wb_idx | output | 5 | Low-byte register index of the pointer to update |
| wb_value | output | 16 | New pointer value |
| illegal | output | 1 | Request was not a legal combination |

## Verification
The bench targets the wrap points. It decrements a pointer at 0x0000 and increments one at 0xFFFF. It adds the largest offset, 63, to 0xFFFF. A design that extends a carry or a borrow past bit 15 would show a wrong address or write-back value in these cases. It also drives the offset mode with the first pointer and uses the invalid selector and the spare mode codes. A design that leaks a write-back or a non-zero address on these requests would corrupt a pointer. It runs back-to-back and gapped requests with changing pointers, so an off-by-one in the output stage or a strobe that stays high is exposed. It also uses absolute requests with the invalid selector, to confirm that the selector has no effect there.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;

   typedef enum logic [2:0] {
      AM_ABS     = 3'd0,
      AM_PTR     = 3'd1,
      AM_OFFSET  = 3'd2,
      AM_DEC_PRE = 3'd3,
      AM_INC_POST = 3'd4
   } addr_mode_e;

   localparam int unsigned SEL_W     = 2;
   localparam int unsigned NUM_PTRS  = 3;
   localparam logic [SEL_W-1:0] SEL_FIRST = 2'd0;

endpackage

// File: rtl/ptr_agen_fetch.sv
module ptr_agen_fetch
   import ptr_agen_pkg::*;
#(
   parameter int unsigned PW    = 16,
   parameter int unsigned NPTRS = NUM_PTRS
) (
   input  logic [PW*NPTRS-1:0] rf_bytes,
   input  logic [SEL_W-1:0]    sel,
   output logic [PW-1:0]       ptr,
   output logic                sel_ok
);

   logic [PW-1:0] ptrs [NPTRS];

   for (genvar i = 0; i < NPTRS; i++) begin : g_slice
      assign ptrs[i] = rf_bytes[i*PW +: PW];
   end

   always_comb begin
      ptr    = '0;
      sel_ok = 1'b0;
      for (int i = 0; i < NPTRS; i++) begin
         if (sel == SEL_W'(i)) begin
            ptr    = ptrs[i];
            sel_ok = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ptr_agen_calc.sv
module ptr_agen_calc
   import ptr_agen_pkg::*;
#(
   parameter int unsigned AW     = 16,
   parameter int unsigned DISP_W = 6
) (
   input  logic [2:0]        mode,
   input  logic [SEL_W-1:0]  sel,
   input  logic              sel_ok,
   input  logic [AW-1:0]     ptr,
   input  logic [AW-1:0]     direct_addr,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     ea,
   output logic              wb_needed,
   output logic [AW-1:0]     wb_val,
   output logic              bad
);

   addr_mode_e    m;
   logic [AW-1:0] operand;
   logic [AW-1:0] sum;

   assign m = addr_mode_e'(mode);

   // one shared adder serves offset, decrement and increment
   always_comb begin
      unique case (m)
         AM_DEC_PRE:  operand = '1;
         AM_INC_POST: operand = AW'(1);
         default:     operand = AW'(disp);
      endcase
   end

   assign sum = ptr + operand;

   always_comb begin
      bad       = 1'b0;
      wb_needed = 1'b0;
      ea        = '0;
      case (m)
         AM_ABS: ea = direct_addr;
         AM_PTR: begin
            bad = !sel_ok;
            ea  = ptr;
         end
         AM_OFFSET: begin
            bad = !sel_ok || (sel == SEL_FIRST);
            ea  = sum;
         end
         AM_DEC_PRE: begin
            bad       = !sel_ok;
            wb_needed = sel_ok;
            ea        = sum;
         end
         AM_INC_POST: begin
            bad       = !sel_ok;
            wb_needed = sel_ok;
            ea        = ptr;
         end
         default: bad = 1'b1;
      endcase
      if (bad) ea = '0;
   end

   assign wb_val = sum;

endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
   import ptr_agen_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 16,
   parameter int unsigned DISP_W   = 6,
   parameter int unsigned RF_IDX_W = 5,
   parameter int unsigned PTR_BASE = 26,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [2:0]             mode,
   input  logic [1:0]             ptr_sel,
   input  logic [AW-1:0]          direct_addr,
   input  logic [DISP_W-1:0]      disp,
   input  logic [AW*NUM_PTRS-1:0] rf_ptr_bytes,
   output logic                   out_valid,
   output logic [AW-1:0]          ea,
   output logic                   wb_en,
   output logic [RF_IDX_W-1:0]    wb_idx,
   output logic [AW-1:0]          wb_value,
   output logic                   illegal
);

   localparam int unsigned RF_DEPTH = 2 ** RF_IDX_W;

   if (AW != 2 * DW) begin : g_bad_aw
      $error("address width must span two register bytes");
   end
   if (DISP_W >= AW) begin : g_bad_disp
      $error("offset width must be below the address width");
   end
   if (PTR_BASE + 2 * NUM_PTRS > RF_DEPTH) begin : g_bad_base
      $error("pointer pairs exceed the register file");
   end
   if (PTR_BASE % 2 != 0) begin : g_bad_align
      $error("pointer pairs must start on an even index");
   end

   logic [AW-1:0]       ptr_c;
   logic                sel_ok_c;
   logic [AW-1:0]       ea_c;
   logic                wbn_c;
   logic [AW-1:0]       wbv_c;
   logic                bad_c;
   logic [RF_IDX_W-1:0] idx_c;

   ptr_agen_fetch #(.PW(AW), .NPTRS(NUM_PTRS)) u_fetch (
      .rf_bytes (rf_ptr_bytes),
      .sel      (ptr_sel),
      .ptr      (ptr_c),
      .sel_ok   (sel_ok_c)
   );

   ptr_agen_calc #(.AW(AW), .DISP_W(DISP_W)) u_calc (
      .mode        (mode),
      .sel         (ptr_sel),
      .sel_ok      (sel_ok_c),
      .ptr         (ptr_c),
      .direct_addr (direct_addr),
      .disp        (disp),
      .ea          (ea_c),
      .wb_needed   (wbn_c),
      .wb_val      (wbv_c),
      .bad         (bad_c)
   );

   assign idx_c = RF_IDX_W'(PTR_BASE + 2 * int'(ptr_sel));

   if (REG_OUT) begin : g_reg
      logic                vq, wq, iq;
      logic [AW-1:0]       eq, valq;
      logic [RF_IDX_W-1:0] xq;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vq   <= 1'b0;
            wq   <= 1'b0;
            iq   <= 1'b0;
            eq   <= '0;
            valq <= '0;
            xq   <= '0;
         end else begin
            vq <= req_valid;
            wq <= req_valid & wbn_c;
            iq <= req_valid & bad_c;
            if (req_valid) begin
               eq   <= ea_c;
               valq <= wbv_c;
               xq   <= idx_c;
            end
         end
      end

      assign out_valid = vq;
      assign wb_en     = wq;
      assign illegal   = iq;
      assign ea        = eq;
      assign wb_value  = valq;
      assign wb_idx    = xq;
   end else begin : g_comb
      assign out_valid = req_valid;
      assign wb_en     = req_valid & wbn_c;
      assign illegal   = req_valid & bad_c;
      assign ea        = ea_c;
      assign wb_value  = wbv_c;
      assign wb_idx    = idx_c;
   end

endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk #(
   parameter int unsigned AW       = 16,
   parameter int unsigned DISP_W   = 6,
   parameter int unsigned RF_IDX_W = 5,
   parameter int unsigned PTR_BASE = 26,
   parameter bit          REG_OUT  = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [2:0]          mode,
   input logic [1:0]          ptr_sel,
   input logic [AW-1:0]       direct_addr,
   input logic [DISP_W-1:0]   disp,
   input logic [AW*3-1:0]     rf_ptr_bytes,
   input logic                out_valid,
   input logic [AW-1:0]       ea,
   input logic                wb_en,
   input logic [RF_IDX_W-1:0] wb_idx,
   input logic [AW-1:0]       wb_value,
   input logic                illegal
);

   localparam logic [AW-1:0] ONE = AW'(1);

   // R9: write-back and illegal are exclusive and always qualified
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (out_valid && !illegal));

   // R2: write-back only ever targets one of the three pair bases
   a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> ((wb_idx == RF_IDX_W'(PTR_BASE)) || (wb_idx == RF_IDX_W'(PTR_BASE + 2))
                 || (wb_idx == RF_IDX_W'(PTR_BASE + 4))));

   if (REG_OUT) begin : g_seq
      a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> out_valid);

      a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> (!out_valid && !wb_en && !illegal));

      a_r1_absolute: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && mode == 3'd0) |=> (ea == $past(direct_addr) && !wb_en && !illegal));

      a_r5_offset_first: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && mode == 3'd2 && ptr_sel == 2'd0) |=> (illegal && !wb_en));

      a_r6_dec_pre: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && mode == 3'd3 && ptr_sel != 2'd3) |=> (wb_en && wb_value == ea));

      a_r7_inc_post: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && mode == 3'd4 && ptr_sel != 2'd3) |=> (wb_en && wb_value == ea + ONE));

      a_r8_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && mode > 3'd4) |=> (illegal && !wb_en && ea == '0));
   end

endmodule

bind ptr_agen ptr_agen_chk #(
   .AW(AW), .DISP_W(DISP_W), .RF_IDX_W(RF_IDX_W), .PTR_BASE(PTR_BASE), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/ptr_agen_tb.sv
`timescale 1ns/1ps
module ptr_agen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  ptr_sel = '0;
   logic [15:0] direct_addr = '0;
   logic [5:0]  disp = '0;
   logic [47:0] rf_ptr_bytes = '0;
   logic        out_valid, wb_en, illegal;
   logic [15:0] ea, wb_value;
   logic [4:0]  wb_idx;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // expected values for the next sample point
   bit          x_valid = 1'b0, x_wb = 1'b0, x_ill = 1'b0;
   logic [15:0] x_ea = '0, x_wbv = '0;
   int          x_idx = 0;
   string       x_tag = "R10";

   always #2.5 clk = ~clk;

   ptr_agen u_dut (
      .clk, .rst_n, .req_valid, .mode, .ptr_sel, .direct_addr, .disp, .rf_ptr_bytes,
      .out_valid, .ea, .wb_en, .wb_idx, .wb_value, .illegal
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(out_valid == x_valid, "R9", "out_valid", int'(out_valid), int'(x_valid));
      chk(wb_en == x_wb, x_tag, "wb_en", int'(wb_en), int'(x_wb));
      chk(illegal == x_ill, x_tag, "illegal", int'(illegal), int'(x_ill));
      if (x_valid || x_tag == "R10")
         chk(ea == x_ea, x_tag, "ea", int'(ea), int'(x_ea));
      if (x_wb) begin
         chk(wb_value == x_wbv, x_tag, "wb_value", int'(wb_value), int'(x_wbv));
         chk(int'(wb_idx) == x_idx, "R2", "wb_idx", int'(wb_idx), x_idx);
      end
   endtask

   // behavioural reference for one request
   task automatic model(input bit v, input int m, input int s, input logic [15:0] d,
                        input int dp, input logic [47:0] rf);
      logic [15:0] p;
      p = (s < 3) ? rf[16*s +: 16] : 16'h0;
      x_valid = v; x_wb = 0; x_ill = 0; x_ea = 16'h0; x_wbv = 16'h0;
      x_idx = 26 + 2 * s;
      if (!v) begin x_tag = "R9"; return; end
      if (m == 0) begin x_ea = d; x_tag = "R1"; end
      else if (m > 4 || s == 3) begin x_ill = 1; x_tag = "R8"; end
      else if (m == 1) begin x_ea = p; x_tag = "R2 R3"; end
      else if (m == 2 && s == 0) begin x_ill = 1; x_tag = "R5"; end
      else if (m == 2) begin x_ea = p + 16'(dp); x_tag = "R4"; end
      else if (m == 3) begin x_ea = p - 16'd1; x_wb = 1; x_wbv = p - 16'd1; x_tag = "R6"; end
      else begin x_ea = p; x_wb = 1; x_wbv = p + 16'd1; x_tag = "R7"; end
   endtask

   task automatic step(input bit v, input int m, input int s, input logic [15:0] d,
                       input int dp, input logic [47:0] rf);
      @(negedge clk);
      compare();
      req_valid = v; mode = 3'(m); ptr_sel = 2'(s); direct_addr = d;
      disp = 6'(dp); rf_ptr_bytes = rf;
      model(v, m, s, d, dp, rf);
   endtask

   initial begin
      // R10: outputs during reset, with a request pending on the inputs
      req_valid = 1'b1; mode = 3'd4; rf_ptr_bytes = 48'h1234_5678_9abc;
      repeat (3) @(negedge clk);
      chk(!out_valid && !wb_en && !illegal, "R10", "flags in reset",
          int'({out_valid, wb_en, illegal}), 0);
      chk(ea == 16'h0, "R10", "ea in reset", int'(ea), 0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      x_tag = "R10";
      // directed corners
      step(1, 0, 3, 16'hFFFF, 0, 48'h0);                    // R1 with invalid selector
      step(1, 1, 0, 16'h0, 0, 48'hCCCC_BBBB_AAAA);          // R2 X
      step(1, 1, 1, 16'h0, 0, 48'hCCCC_BBBB_AAAA);          // R2 Y
      step(1, 1, 2, 16'h0, 0, 48'hCCCC_BBBB_AAAA);          // R2 Z
      step(1, 3, 1, 16'h0, 0, 48'h0000_0000_0000);          // R6 wrap 0 -> FFFF
      step(1, 4, 2, 16'h0, 0, 48'hFFFF_0000_0000);          // R7 wrap FFFF -> 0
      step(1, 2, 2, 16'h0, 63, 48'hFFFF_0000_0000);         // R4 wrap to 003E
      step(1, 2, 1, 16'h0, 0, 48'h0000_4321_0000);          // R4 zero offset
      step(1, 2, 0, 16'h0, 5, 48'h0000_0000_1111);          // R5 X with offset
      step(0, 0, 0, 16'h0, 0, 48'h0);                       // R9 gap
      step(1, 3, 3, 16'h0, 0, 48'h1);                       // R8 invalid selector
      step(1, 5, 1, 16'h55, 0, 48'h1);                      // R8 spare codes
      step(1, 6, 2, 16'h55, 0, 48'h1);
      step(1, 7, 0, 16'h55, 0, 48'h1);
      step(1, 4, 0, 16'h0, 0, 48'h0000_0000_00FF);          // R7 carry into high byte
      step(1, 3, 0, 16'h0, 0, 48'h0000_0000_0100);          // R6 borrow from high byte
      // random mix, back-to-back and gapped
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 5) != 0, int'($urandom % 8), int'($urandom % 4),
              16'($urandom), int'($urandom % 64), {16'($urandom), 32'($urandom)});
      end
      step(0, 0, 0, 16'h0, 0, 48'h0);
      step(0, 0, 0, 16'h0, 0, 48'h0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule